// File: doc/BRIEF.md
# PTP Receive Event Classifier

This block sits behind a receive frame parser and decides, frame by frame, whether an arriving frame is a precision-time event message that the receive timestamp capture latch must keep. The parser presents the header fields in a cycle marked by `hdr_vld`: ethertype, a UDP flag with the destination port, the PTP version, the version 1 control byte and the version 2 message ID. It marks the last beat of the frame with `frm_end`, together with an error flag. When the frame ends cleanly, the block sends a single-cycle `stamp_req` pulse if the most recent header seen in that frame matched the configured filter.

Software sets up the filter through a 4-bit control word, a 32-bit match word and two path enables. The control word carries a receive enable and a mode that selects one of four ways to match. Version 1 over UDP matches one control byte. Version 2 over the PTP ethertype matches one message ID. Version 2 over either the ethertype or UDP also matches one message ID. The last mode accepts every version 2 event message. The UDP port and the match values are held in separate byte lanes of the match word. Only one version 1 message type can be chosen at a time, and no mode stamps all traffic.

Top module: `ptp_rx_event_classifier`

## Requirements
- R1: `cfg_ctl[0]` is the receive enable and `cfg_ctl[3:1]` is the mode. The mode values are 0 for version 2 over the ethertype, 1 for version 1 over UDP, 2 for version 2 over the ethertype or UDP, and 5 for all version 2 events. Modes 3, 4, 6 and 7 never match.
- R2: In mode 1 a frame matches when its version is 1, its UDP flag is set, its destination port equals `cfg_match[31:16]` (319 in normal use), `cfg_udp_en` is 1, and its control byte equals `cfg_match[7:0]` (Sync = 0, Delay_Req = 1).
- R3: In mode 0 a frame matches when its version is 2, its ethertype is 0x88F7, `cfg_etype_en` is 1, and its message ID, zero-extended to 8 bits, equals `cfg_match[15:8]` (Sync 0x00, Delay_Req 0x01, Pdelay_Req 0x02, Pdelay_Resp 0x03).
- R4: In mode 2 a version 2 frame with a matching message ID matches when either the ethertype path or the UDP port path of R2 and R3 qualifies.
- R5: In mode 5 a version 2 frame on either path matches when its message ID is 0 to 3. IDs 4 to 15, which include all general messages, never match.
- R6: When `cfg_etype_en` is 0 the ethertype path never qualifies. When `cfg_udp_en` is 0 the UDP path never qualifies.
- R7: While `cfg_ctl[0]` is 0 no request is issued. Clearing it in the middle of a frame discards a decision that has already been taken for that frame.
- R8: A frame whose `frm_end` beat carries `frm_err` = 1 produces no request.
- R9: `stamp_req` is a one-cycle pulse in the cycle after the `frm_end` beat. A frame whose header and end fall in the same beat is classified on that beat.
- R10: A frame gives at most one request. If a frame carries several header beats, the most recent one decides. No request appears without a frame end.
- R11: After synchronous reset `stamp_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ctl | input | 4 | Bit 0 receive enable, bits 3:1 match mode |
| cfg_match | input | 32 | [31:16] UDP port, [15:8] v2 message ID, [7:0] v1 control |
| cfg_etype_en | input | 1 | Enable the ethertype path |
| cfg_udp_en | input | 1 | Enable the UDP port path |
| hdr_vld | input | 1 | Header fields valid this cycle |
| hdr_etype | input | 16 | Frame ethertype |
| hdr_udp | input | 1 | Frame is UDP |
| hdr_dport | input | 16 | UDP destination port |
| hdr_ver | input | 4 | PTP version |
| hdr_v1_ctl | input | 8 | Version 1 control byte |
| hdr_msg_id | input | 4 | Version 2 message ID |
| frm_end | input | 1 | Last beat of the frame |
| frm_err | input | 1 | Frame error, valid with frm_end |
| stamp_req | output | 1 | One-cycle timestamp capture request |

## Verification
Two things can happen in the same beat. The header decision and the frame-end decision coincide in single-beat frames, and the end of one frame can sit next to the header of the next. The bench drives single-beat frames back to back, each carrying its own header and end. It expects a separate pulse for each frame in consecutive cycles. It also drives frames whose header and end are apart, carrying a second header, or with the enable dropped in between. A queue of expected outcomes, one entry per frame end, is compared against `stamp_req` one cycle later. Any pulse that has no matching entry counts as a miscompare.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
    localparam int ETYPE_W = 16;
    localparam int PORT_W  = 16;
    localparam int VER_W   = 4;
    localparam int ID_W    = 4;
    localparam int V1C_W   = 8;
    localparam int MREG_W  = 32;
    localparam int CTL_W   = 4;

    // match mode, held in control bits 3:1
    typedef enum logic [2:0] {
        MD_V2_L2    = 3'd0,
        MD_V1_UDP   = 3'd1,
        MD_V2_BOTH  = 3'd2,
        MD_V2_EVENT = 3'd5
    } mode_e;

    typedef struct packed {
        logic [ETYPE_W-1:0] etype;
        logic               udp;
        logic [PORT_W-1:0]  dport;
        logic [VER_W-1:0]   ver;
        logic [V1C_W-1:0]   v1_ctl;
        logic [ID_W-1:0]    msg_id;
    } hdr_t;

    typedef struct packed {
        logic              rx_en;
        logic [2:0]        mode;
        logic [MREG_W-1:0] mreg;
        logic              etype_en;
        logic              udp_en;
    } cfg_t;

    // byte lanes of the match word
    function automatic logic [PORT_W-1:0] mreg_port(input logic [MREG_W-1:0] m);
        return m[31:16];
    endfunction

    function automatic logic [7:0] mreg_v2_id(input logic [MREG_W-1:0] m);
        return m[15:8];
    endfunction

    function automatic logic [V1C_W-1:0] mreg_v1_ctl(input logic [MREG_W-1:0] m);
        return m[7:0];
    endfunction
endpackage

// File: rtl/ptpc_match.sv
module ptpc_match
    import ptpc_pkg::*;
#(
    parameter logic [ETYPE_W-1:0] PTP_ETYPE   = 16'h88F7,
    parameter int                 EVT_ID_LAST = 3
) (
    input  hdr_t hdr,
    input  cfg_t cfg,
    output logic hit
);
    logic path_l2, path_l4, is_v1, is_v2, id_eq, id_evt, v1_eq;

    assign path_l2 = cfg.etype_en && (hdr.etype == PTP_ETYPE);
    assign path_l4 = cfg.udp_en && hdr.udp && (hdr.dport == mreg_port(cfg.mreg));
    assign is_v1   = (hdr.ver == VER_W'(1));
    assign is_v2   = (hdr.ver == VER_W'(2));
    assign id_eq   = ({{(8-ID_W){1'b0}}, hdr.msg_id} == mreg_v2_id(cfg.mreg));
    assign id_evt  = (32'(hdr.msg_id) <= 32'(EVT_ID_LAST));
    assign v1_eq   = (hdr.v1_ctl == mreg_v1_ctl(cfg.mreg));

    always_comb begin
        case (cfg.mode)
            MD_V2_L2:    hit = is_v2 && path_l2 && id_eq;
            MD_V1_UDP:   hit = is_v1 && path_l4 && v1_eq;
            MD_V2_BOTH:  hit = is_v2 && (path_l2 || path_l4) && id_eq;
            MD_V2_EVENT: hit = is_v2 && (path_l2 || path_l4) && id_evt;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptpc_track.sv
module ptpc_track (
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic hdr_vld,
    input  logic hit,
    input  logic frm_end,
    input  logic frm_err,
    output logic stamp_req
);
    logic armed;
    logic decide;

    // the latest header of the frame decides; a header on the end beat wins
    assign decide = hdr_vld ? (hit && rx_en) : armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            stamp_req <= 1'b0;
        end else begin
            stamp_req <= frm_end && rx_en && !frm_err && decide;
            if (frm_end || !rx_en)
                armed <= 1'b0;
            else if (hdr_vld)
                armed <= hit;
        end
    end
endmodule

// File: rtl/ptp_rx_event_classifier.sv
module ptp_rx_event_classifier
    import ptpc_pkg::*;
#(
    parameter logic [15:0] PTP_ETYPE   = 16'h88F7,
    parameter int          EVT_ID_LAST = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  cfg_ctl,
    input  logic [31:0] cfg_match,
    input  logic        cfg_etype_en,
    input  logic        cfg_udp_en,
    input  logic        hdr_vld,
    input  logic [15:0] hdr_etype,
    input  logic        hdr_udp,
    input  logic [15:0] hdr_dport,
    input  logic [3:0]  hdr_ver,
    input  logic [7:0]  hdr_v1_ctl,
    input  logic [3:0]  hdr_msg_id,
    input  logic        frm_end,
    input  logic        frm_err,
    output logic        stamp_req
);
    hdr_t hdr;
    cfg_t cfg;
    logic hit;

    assign hdr = '{etype: hdr_etype, udp: hdr_udp, dport: hdr_dport,
                   ver: hdr_ver, v1_ctl: hdr_v1_ctl, msg_id: hdr_msg_id};
    assign cfg = '{rx_en: cfg_ctl[0], mode: cfg_ctl[3:1], mreg: cfg_match,
                   etype_en: cfg_etype_en, udp_en: cfg_udp_en};

    ptpc_match #(.PTP_ETYPE(PTP_ETYPE), .EVT_ID_LAST(EVT_ID_LAST)) u_match (
        .hdr (hdr),
        .cfg (cfg),
        .hit (hit)
    );

    ptpc_track u_track (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (cfg.rx_en),
        .hdr_vld   (hdr_vld),
        .hit       (hit),
        .frm_end   (frm_end),
        .frm_err   (frm_err),
        .stamp_req (stamp_req)
    );
endmodule

// File: rtl/ptpc_chk.sv
module ptpc_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cfg_ctl,
    input logic       hdr_vld,
    input logic [3:0] hdr_ver,
    input logic [3:0] hdr_msg_id,
    input logic       frm_end,
    input logic       frm_err,
    input logic       stamp_req
);
    logic mode_rsvd;
    assign mode_rsvd = !(cfg_ctl[3:1] inside {3'd0, 3'd1, 3'd2, 3'd5});

    AST_RST_QUIET: assert property (@(posedge clk) rst |=> !stamp_req); // R11
    AST_REQ_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        stamp_req |-> $past(frm_end)); // R9
    AST_ERR_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        frm_end && frm_err |=> !stamp_req); // R8
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        frm_end && !cfg_ctl[0] |=> !stamp_req); // R7
    AST_GENERAL_NEVER: assert property (@(posedge clk) disable iff (rst)
        hdr_vld && frm_end && cfg_ctl[3:1] == 3'd5 && hdr_ver == 4'd2 && hdr_msg_id > 4'd3
        |=> !stamp_req); // R5
    AST_RSVD_MODE: assert property (@(posedge clk) disable iff (rst)
        hdr_vld && frm_end && mode_rsvd |=> !stamp_req); // R1
endmodule

bind ptp_rx_event_classifier ptpc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_ctl    (cfg_ctl),
    .hdr_vld    (hdr_vld),
    .hdr_ver    (hdr_ver),
    .hdr_msg_id (hdr_msg_id),
    .frm_end    (frm_end),
    .frm_err    (frm_err),
    .stamp_req  (stamp_req)
);

// File: tb/test_ptp_rx_event_classifier.sv
`timescale 1ns/1ps
module test_ptp_rx_event_classifier;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_ctl = '0;
    logic [31:0] cfg_match = '0;
    logic        cfg_etype_en = 1'b1, cfg_udp_en = 1'b1;
    logic        hdr_vld = 1'b0, hdr_udp = 1'b0, frm_end = 1'b0, frm_err = 1'b0;
    logic [15:0] hdr_etype = '0, hdr_dport = '0;
    logic [3:0]  hdr_ver = '0, hdr_msg_id = '0;
    logic [7:0]  hdr_v1_ctl = '0;
    logic        stamp_req;

    int n_vec = 0, n_bad = 0;
    bit exp_q[$];
    string tag_q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    ptp_rx_event_classifier i_ptp_rx_event_classifier (
        .clk(clk), .rst(rst), .cfg_ctl(cfg_ctl), .cfg_match(cfg_match),
        .cfg_etype_en(cfg_etype_en), .cfg_udp_en(cfg_udp_en), .hdr_vld(hdr_vld),
        .hdr_etype(hdr_etype), .hdr_udp(hdr_udp), .hdr_dport(hdr_dport),
        .hdr_ver(hdr_ver), .hdr_v1_ctl(hdr_v1_ctl), .hdr_msg_id(hdr_msg_id),
        .frm_end(frm_end), .frm_err(frm_err), .stamp_req(stamp_req));

    // expected match, taken from the requirement text
    function automatic bit want(input logic [15:0] et, input bit udp, input logic [15:0] dp,
                                input logic [3:0] ver, input logic [7:0] v1, input logic [3:0] id);
        bit l2 = cfg_etype_en && et == 16'h88F7;
        bit l4 = cfg_udp_en && udp && dp == cfg_match[31:16];
        bit r;
        case (cfg_ctl[3:1])
            3'd0: r = ver == 2 && l2 && {4'h0, id} == cfg_match[15:8];
            3'd1: r = ver == 1 && l4 && v1 == cfg_match[7:0];
            3'd2: r = ver == 2 && (l2 || l4) && {4'h0, id} == cfg_match[15:8];
            3'd5: r = ver == 2 && (l2 || l4) && id < 4;
            default: r = 0;
        endcase
        return r && cfg_ctl[0];
    endfunction

    task automatic put_hdr(input logic [15:0] et, input bit udp, input logic [15:0] dp,
                           input logic [3:0] ver, input logic [7:0] v1, input logic [3:0] id);
        hdr_vld = 1; hdr_etype = et; hdr_udp = udp; hdr_dport = dp;
        hdr_ver = ver; hdr_v1_ctl = v1; hdr_msg_id = id;
    endtask

    // driver: one frame, single beat or header-then-end
    task automatic send(input string tag, input bit split, input bit err,
                        input logic [15:0] et, input bit udp, input logic [15:0] dp,
                        input logic [3:0] ver, input logic [7:0] v1, input logic [3:0] id);
        bit e;
        @(negedge clk);
        e = want(et, udp, dp, ver, v1, id) && !err;
        put_hdr(et, udp, dp, ver, v1, id);
        if (split) begin
            @(negedge clk); hdr_vld = 0;
            @(negedge clk);
        end
        frm_end = 1; frm_err = err;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); hdr_vld = 0; frm_end = 0; frm_err = 0;
    endtask

    // monitor: one compare per frame end, and no stray pulse elsewhere
    initial begin
        bit ended, e;
        string t;
        forever begin
            @(posedge clk); ended = frm_end && !rst;
            @(negedge clk);
            if (ended) begin
                n_vec++;
                if (exp_q.size() == 0) begin
                    n_bad++; $display("FAIL R10: no expectation queued, stamp_req=%0b expected none", stamp_req);
                end else begin
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    if (stamp_req !== e) begin
                        n_bad++; $display("FAIL %s: stamp_req=%0b expected %0b", t, stamp_req, e);
                    end
                end
            end else if (stamp_req !== 1'b0 && !rst) begin
                n_bad++; $display("FAIL R10: stamp_req=%0b without frame end, expected 0", stamp_req);
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        n_bad++; $display("FAIL watchdog: run active=1 expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (stamp_req !== 1'b0) begin n_bad++; $display("FAIL R11: stamp_req=%0b expected 0", stamp_req); end
        rst = 0;

        // R3: version 2 over ethertype, Sync selected
        cfg_ctl = 4'b0001; cfg_match = {16'd319, 8'h00, 8'h00};
        send("R3", 0, 0, 16'h88F7, 0, 0, 2, 0, 0);
        send("R3", 1, 0, 16'h88F7, 0, 0, 2, 0, 1);
        send("R3", 0, 0, 16'h0800, 0, 0, 2, 0, 0);
        send("R3", 0, 0, 16'h88F7, 0, 0, 1, 0, 0);
        cfg_etype_en = 0;
        send("R6", 0, 0, 16'h88F7, 0, 0, 2, 0, 0);
        cfg_etype_en = 1;

        // R2: version 1 over UDP, Delay_Req selected
        cfg_ctl = 4'b0011; cfg_match = {16'd319, 8'h00, 8'h01};
        send("R2", 1, 0, 16'h0800, 1, 319, 1, 1, 0);
        send("R2", 0, 0, 16'h0800, 1, 319, 1, 0, 0);
        send("R2", 0, 0, 16'h0800, 1, 320, 1, 1, 0);
        send("R2", 0, 0, 16'h0800, 0, 319, 1, 1, 0);
        cfg_udp_en = 0;
        send("R6", 0, 0, 16'h0800, 1, 319, 1, 1, 0);
        cfg_udp_en = 1;

        // R4: either path, Pdelay_Req selected
        cfg_ctl = 4'b0101; cfg_match = {16'd319, 8'h02, 8'h00};
        send("R4", 0, 0, 16'h0800, 1, 319, 2, 0, 2);
        send("R4", 1, 0, 16'h88F7, 0, 0, 2, 0, 2);
        send("R4", 0, 0, 16'h88F7, 0, 0, 2, 0, 3);
        send("R4", 0, 0, 16'h0800, 0, 0, 2, 0, 2);

        // R5: every version 2 event ID, nothing else
        cfg_ctl = 4'b1011;
        for (int i = 0; i < 16; i++) send("R5", 0, 0, 16'h88F7, 0, 0, 2, 0, 4'(i));
        send("R5", 0, 0, 16'h0800, 1, 319, 2, 0, 3);
        send("R5", 0, 0, 16'h88F7, 0, 0, 1, 0, 0);

        // R1: reserved modes never match
        cfg_ctl = 4'b0111; send("R1", 0, 0, 16'h88F7, 1, 319, 2, 0, 0);
        cfg_ctl = 4'b1001; send("R1", 0, 0, 16'h88F7, 1, 319, 2, 0, 0);
        cfg_ctl = 4'b1111; send("R1", 0, 0, 16'h88F7, 1, 319, 2, 0, 0);

        // R7: receive enable clear
        cfg_ctl = 4'b1010; send("R7", 0, 0, 16'h88F7, 0, 0, 2, 0, 0);
        // R8: errored frame
        cfg_ctl = 4'b1011; send("R8", 1, 1, 16'h88F7, 0, 0, 2, 0, 0);
        send("R8", 0, 1, 16'h88F7, 0, 0, 2, 0, 1);

        // R7: enable dropped mid-frame discards the armed decision
        @(negedge clk); put_hdr(16'h88F7, 0, 0, 2, 0, 0);
        @(negedge clk); hdr_vld = 0; cfg_ctl[0] = 0;
        @(negedge clk); cfg_ctl[0] = 1;
        @(negedge clk); frm_end = 1; exp_q.push_back(0); tag_q.push_back("R7");
        @(negedge clk); frm_end = 0;

        // R10: latest header of a frame decides
        @(negedge clk); put_hdr(16'h88F7, 0, 0, 2, 0, 1);
        @(negedge clk); put_hdr(16'h88F7, 0, 0, 2, 0, 9);
        @(negedge clk); hdr_vld = 0; frm_end = 1; exp_q.push_back(0); tag_q.push_back("R10");
        @(negedge clk); frm_end = 0;
        @(negedge clk); put_hdr(16'h88F7, 0, 0, 2, 0, 9);
        @(negedge clk); put_hdr(16'h88F7, 0, 0, 2, 0, 2);
        @(negedge clk); hdr_vld = 0; frm_end = 1; exp_q.push_back(1); tag_q.push_back("R10");
        @(negedge clk); frm_end = 0;

        // R9: back-to-back single-beat frames, one pulse each
        @(negedge clk); put_hdr(16'h88F7, 0, 0, 2, 0, 0); frm_end = 1;
        exp_q.push_back(1); tag_q.push_back("R9");
        @(negedge clk); put_hdr(16'h88F7, 0, 0, 2, 0, 8);
        exp_q.push_back(0); tag_q.push_back("R9");
        @(negedge clk); put_hdr(16'h88F7, 0, 0, 2, 0, 3);
        exp_q.push_back(1); tag_q.push_back("R9");
        @(negedge clk); hdr_vld = 0; frm_end = 0;

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++; $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule